// File: doc/BRIEF.md
# Accumulator Instruction Sequencer

This block is the control and datapath core of a small 16-bit machine with a single accumulator. It fetches instruction words from a synchronous 4096 x 16 memory and decodes them. It then executes the seven memory-reference operations: logical AND, add, load, store, unconditional branch, branch-and-save, and increment-and-skip-if-zero. Each operation comes in a direct form and an indirect form. An instruction word carries the mode flag in bit 15, the operation code in bits 14..12 and a 12-bit address in bits 11..0. Codes 0 to 6 name the operations listed above, in that order. Code 7 is not executed here. It is passed to neighbouring register and I/O units through a two-bit one-hot strobe, and those units read the instruction word from `ir_o`.

There is no encoded state machine. A 4-bit step counter is decoded into sixteen one-hot timing lines. Every register transfer is enabled by the product of a timing line, the decoded operation and the mode flag. Memory returns read data in the cycle after the address is presented, so each read takes one step to issue and the following step to capture. Every instruction shares the same first five steps. After that, each instruction runs only as many steps as it needs and then clears the counter.

Top module: `acc_seq_core`

## Requirements
- R1: While reset is low, the block loads PC with START_ADDR (default 0x010), clears AC and E, holds the step counter at step 0 (`tstate_o` = 0x0001) and keeps `mem_we` low.
- R2: Fetch works as follows. At step 0, AR takes PC. At step 1, PC increments. At step 2, IR, AR (bits 11..0) and the mode flag load from the returned word. `mem_addr` always shows AR.
- R3: `tstate_o` is one-hot and advances by one step per cycle. It returns to step 0 after the last step of each instruction. No instruction goes past step 8.
- R4: When the mode flag is 1 and the code is not 7, step 4 replaces AR with bits 11..0 of the word read at AR. All later operand accesses then use that pointer.
- R5: AND, ADD and LDA read the operand into DR at step 6. At step 7 they write AC&DR, AC+DR or DR into AC. ADD places the carry out of bit 15 into E. AND and LDA leave E unchanged.
- R6: STA drives `mem_we` high for exactly one cycle, at step 5, with `mem_addr` = AR and `mem_wdata` = AC.
- R7: BUN loads PC from AR at step 5 and ends the instruction.
- R8: BSA writes the zero-extended PC to memory at AR at step 5 and loads PC with AR+1 at step 6.
- R9: ISZ reads the word, increments it at step 7 and writes it back at step 8. If the written value is zero, PC increments once more, so the next instruction word is skipped.
- R10: For code 7, at step 3, `grp_strobe_o` pulses bit 0 when the mode flag is 0 and bit 1 when it is 1. No memory write happens, and the next fetch starts.
- R11: Once `halt` is seen high at a clock edge, all registers stop updating, `mem_we` and `grp_strobe_o` stay low, and this holds until reset even if `halt` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt | input | 1 | Stops the machine until the next reset |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| mem_addr | output | 12 | Memory address (AR) |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| ir_o | output | 16 | Current instruction word, for the code-7 units |
| acc_o | output | 16 | Accumulator |
| e_o | output | 1 | Carry flag E |
| pc_o | output | 12 | Program counter |
| tstate_o | output | 16 | One-hot timing lines T0..T15 |
| grp_strobe_o | output | 2 | Code-7 hand-off: bit 0 register group, bit 1 I/O group |

## Verification
A single program mixes direct and indirect forms of every operation, so a wrong pointer step changes which word is loaded or stored. One ADD overflows and another does not, which separates carry capture in E from a stale E. A later AND leaves E set, which shows that AND does not touch the flag. ISZ runs once on a value that stays non-zero and once on a value that wraps to zero, so a skip that is missing or unconditional is exposed by the fetch addresses. Code 7 is issued with both mode values, and halt is raised while a branch loop is running.

// File: rtl/acc_seq_pkg.sv
// Shared types for the accumulator sequencer: operation codes and the
// arithmetic selector. Assumes a 3-bit operation field.
package acc_seq_pkg;
    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_EXT = 3'd7
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_AND  = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_PASS = 2'd2
    } alu_sel_e;
endpackage

// File: rtl/acc_step_timer.sv
// Step counter with a one-hot decode of its value. It advances once per
// cycle while run is high and returns to zero when clr is high.
// Assumes the caller clears it before it can wrap.
module acc_step_timer #(
    parameter int unsigned SC_W = 4,
    localparam int unsigned N_T = 1 << SC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           clr,
    output logic [N_T-1:0] tstate
);
    logic [SC_W-1:0] sc_q;

    // Counter: clear on the final step, otherwise step forward.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_q <= '0;
        end else if (run) begin
            if (clr) sc_q <= '0;
            else     sc_q <= sc_q + 1'b1;
        end
    end

    // One decoder line per counter value.
    for (genvar g = 0; g < N_T; g++) begin : g_dec
        assign tstate[g] = (sc_q == SC_W'(g));
    end
endmodule

// File: rtl/acc_op_decode.sv
// Decodes the operation field into one-hot lines D0..D(2^OP_W-1).
// Purely combinational.
module acc_op_decode #(
    parameter int unsigned OP_W = 3,
    localparam int unsigned N_D = 1 << OP_W
) (
    input  logic [OP_W-1:0] op,
    output logic [N_D-1:0]  d
);
    for (genvar g = 0; g < N_D; g++) begin : g_dec
        assign d[g] = (op == OP_W'(g));
    end
endmodule

// File: rtl/acc_alu.sv
// Accumulator arithmetic: AND, add with carry out, and pass-through.
// Combinational. The carry is meaningful only for the add selection.
module acc_alu
    import acc_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_sel_e          sel,
    output logic [DATA_W-1:0] y,
    output logic              cout
);
    logic [DATA_W:0] sum;

    // Full-width sum so the carry out of the top bit is kept.
    assign sum = {1'b0, a} + {1'b0, b};

    // Result select.
    always_comb begin
        cout = 1'b0;
        case (sel)
            ALU_AND: y = a & b;
            ALU_ADD: begin
                y    = sum[DATA_W-1:0];
                cout = sum[DATA_W];
            end
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc_seq_core.sv
// Fetch / decode / execute sequencer for memory-reference instructions.
// Assumes a memory whose read data arrives one cycle after the address.
// Every transfer is enabled by timing line x decoded op x mode flag.
module acc_seq_core
    import acc_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SC_W   = 4,
    parameter logic [ADDR_W-1:0] START_ADDR = 'h010,
    localparam int unsigned N_T   = 1 << SC_W,
    localparam int unsigned N_D   = 1 << OP_W,
    localparam int unsigned MODE_BIT = DATA_W - 1,
    localparam int unsigned OP_LSB   = DATA_W - 1 - OP_W,
    localparam int unsigned PAD_W    = DATA_W - ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] ir_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              e_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [N_T-1:0]    tstate_o,
    output logic [1:0]        grp_strobe_o
);
    logic [ADDR_W-1:0] pc_q, ar_q;
    logic [DATA_W-1:0] ir_q, dr_q, ac_q;
    logic              e_q, i_q, halted_q;
    logic              run;
    logic [N_T-1:0]    t;
    logic [N_D-1:0]    d;
    logic              sc_clr;
    logic              ar_from_pc, ar_from_mem, ar_ptr, ar_inc;
    logic              pc_from_ar, pc_step;
    logic              dr_load, dr_inc, ac_load, e_load, ir_load;
    logic              mem_op;
    logic              dr_zero;
    alu_sel_e          alu_sel;
    logic [DATA_W-1:0] alu_y;
    logic              alu_c;

    assign run = !(halt || halted_q);

    acc_step_timer #(.SC_W(SC_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (sc_clr),
        .tstate (t)
    );

    acc_op_decode #(.OP_W(OP_W)) u_dec (
        .op (ir_q[OP_LSB +: OP_W]),
        .d  (d)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .a    (ac_q),
        .b    (dr_q),
        .sel  (alu_sel),
        .y    (alu_y),
        .cout (alu_c)
    );

    // Control products: timing line x operation line x mode flag.
    assign mem_op      = !d[OP_EXT];
    assign dr_zero     = (dr_q == '0);
    assign ar_from_pc  = t[0];
    assign ir_load     = t[2];
    assign ar_from_mem = t[2];
    assign ar_ptr      = t[4] && mem_op && i_q;
    assign ar_inc      = t[5] && d[OP_BSA];
    assign pc_step     = t[1] || (t[8] && d[OP_ISZ] && dr_zero);
    assign pc_from_ar  = (t[5] && d[OP_BUN]) || (t[6] && d[OP_BSA]);
    assign dr_load     = t[6] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]);
    assign dr_inc      = t[7] && d[OP_ISZ];
    assign ac_load     = t[7] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA]);
    assign e_load      = t[7] && d[OP_ADD];
    assign sc_clr      = (t[3] && d[OP_EXT])
                       || (t[5] && (d[OP_STA] || d[OP_BUN]))
                       || (t[6] && d[OP_BSA])
                       || (t[7] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA]))
                       || (t[8] && d[OP_ISZ]);

    // Arithmetic select from the decoded operation.
    always_comb begin
        if (d[OP_AND])      alu_sel = ALU_AND;
        else if (d[OP_ADD]) alu_sel = ALU_ADD;
        else                alu_sel = ALU_PASS;
    end

    // Halt latch: set by the halt input, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    halted_q <= 1'b0;
        else if (halt) halted_q <= 1'b1;
    end

    // Program counter: start address, fetch step, skip, branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= START_ADDR;
        end else if (run) begin
            if (pc_from_ar)   pc_q <= ar_q;
            else if (pc_step) pc_q <= pc_q + 1'b1;
        end
    end

    // Address register: fetch address, instruction field, pointer, BSA step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ar_q <= '0;
        end else if (run) begin
            if (ar_from_pc)                 ar_q <= pc_q;
            else if (ar_from_mem || ar_ptr) ar_q <= mem_rdata[ADDR_W-1:0];
            else if (ar_inc)                ar_q <= ar_q + 1'b1;
        end
    end

    // Instruction register and mode flag, captured from the fetch read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
            i_q  <= 1'b0;
        end else if (run && ir_load) begin
            ir_q <= mem_rdata;
            i_q  <= mem_rdata[MODE_BIT];
        end
    end

    // Data register: operand capture and ISZ increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q <= '0;
        end else if (run) begin
            if (dr_load)     dr_q <= mem_rdata;
            else if (dr_inc) dr_q <= dr_q + 1'b1;
        end
    end

    // Accumulator and carry flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac_q <= '0;
            e_q  <= 1'b0;
        end else if (run) begin
            if (ac_load) ac_q <= alu_y;
            if (e_load)  e_q  <= alu_c;
        end
    end

    // Memory write port: STA and BSA at step 5, ISZ at step 8.
    assign mem_we = run && ((t[5] && (d[OP_STA] || d[OP_BSA])) || (t[8] && d[OP_ISZ]));

    // Write data chooses by operation.
    always_comb begin
        if (d[OP_STA])      mem_wdata = ac_q;
        else if (d[OP_BSA]) mem_wdata = {{PAD_W{1'b0}}, pc_q};
        else                mem_wdata = dr_q;
    end

    assign mem_addr     = ar_q;
    assign ir_o         = ir_q;
    assign acc_o        = ac_q;
    assign e_o          = e_q;
    assign pc_o         = pc_q;
    assign tstate_o     = t;
    assign grp_strobe_o = (run && t[3] && d[OP_EXT]) ? {i_q, !i_q} : 2'b00;
endmodule

// File: rtl/acc_seq_chk.sv
// Protocol checker for acc_seq_core. Observes ports and the halt latch.
module acc_seq_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SC_W   = 4,
    parameter logic [ADDR_W-1:0] START_ADDR = 'h010,
    localparam int unsigned N_T = 1 << SC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic              halted_q,
    input logic [ADDR_W-1:0] pc_o,
    input logic [DATA_W-1:0] acc_o,
    input logic              mem_we,
    input logic [N_T-1:0]    tstate_o,
    input logic [1:0]        grp_strobe_o
);
    // R1: reset leaves the start address, empty AC and step 0.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_o == START_ADDR && acc_o == '0 && tstate_o[0]));

    // R3: exactly one timing line is active.
    assert_onehot_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tstate_o) == 1);

    // R3: the longest instruction returns to step 0 after step 8.
    assert_max_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o[8] && !halt && !halted_q) |=> tstate_o[0]);

    // R2: the fetch step advances PC by one.
    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tstate_o[1] && !halt && !halted_q) |=> (pc_o == $past(pc_o) + 1'b1));

    // R6: writes occur only in the write steps.
    assert_write_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (tstate_o[5] || tstate_o[8]));

    // R10: hand-off strobe is one-hot and only at step 3.
    assert_strobe_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_strobe_o != 2'b00) |-> (tstate_o[3] && $onehot0(grp_strobe_o)));

    // R11: after halt is seen, state is frozen and nothing is written.
    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ($stable(pc_o) && $stable(acc_o) && $stable(tstate_o) && !mem_we));
endmodule

bind acc_seq_core acc_seq_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SC_W       (SC_W),
    .START_ADDR (START_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt         (halt),
    .halted_q     (halted_q),
    .pc_o         (pc_o),
    .acc_o        (acc_o),
    .mem_we       (mem_we),
    .tstate_o     (tstate_o),
    .grp_strobe_o (grp_strobe_o)
);

// File: tb/test_acc_seq_core.sv
`timescale 1ns/100ps
module test_acc_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt = 1'b0;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] ir_o, acc_o;
    logic        e_o;
    logic [11:0] pc_o;
    logic [15:0] tstate_o;
    logic [1:0]  grp_strobe_o;

    int tests = 0;
    int fails = 0;
    bit chk_on = 0;
    int n_reg_strobe = 0, n_io_strobe = 0;
    bit saw_030 = 0, saw_019 = 0;

    always #2.5 clk = ~clk;

    acc_seq_core i_acc_seq_core (
        .clk(clk), .rst_n(rst_n), .halt(halt), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .ir_o(ir_o), .acc_o(acc_o), .e_o(e_o), .pc_o(pc_o),
        .tstate_o(tstate_o), .grp_strobe_o(grp_strobe_o)
    );

    // Memory attached to the DUT: read data one cycle after the address.
    logic [15:0] mem [4096];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    // Behavioural reference: instruction schedules per step.
    logic [15:0] ref_mem [4096];
    logic [11:0] m_pc, m_ar;
    logic [15:0] m_ir, m_dr, m_ac, m_tmp;
    logic        m_e, m_i, m_halted;
    int          m_sc;
    logic [2:0]  m_op;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 12'h010; m_ar = 0; m_ir = 0; m_dr = 0; m_ac = 0;
            m_e = 0; m_i = 0; m_halted = 0; m_sc = 0;
        end else if (m_halted || halt) begin
            m_halted = 1;
        end else begin
            m_op = m_ir[14:12];
            case (m_sc)
                0: begin m_ar = m_pc; m_sc = 1; end
                1: begin m_pc = m_pc + 1; m_sc = 2; end
                2: begin m_ir = ref_mem[m_ar]; m_ar = m_ir[11:0]; m_i = m_ir[15]; m_sc = 3; end
                3: m_sc = (m_op == 3'd7) ? 0 : 4;
                4: begin
                    if (m_i) begin m_tmp = ref_mem[m_ar]; m_ar = m_tmp[11:0]; end
                    m_sc = 5;
                end
                5: case (m_op)
                    3'd3: begin ref_mem[m_ar] = m_ac; m_sc = 0; end
                    3'd4: begin m_pc = m_ar; m_sc = 0; end
                    3'd5: begin ref_mem[m_ar] = {4'h0, m_pc}; m_ar = m_ar + 1; m_sc = 6; end
                    default: m_sc = 6;
                endcase
                6: if (m_op == 3'd5) begin m_pc = m_ar; m_sc = 0; end
                   else begin m_dr = ref_mem[m_ar]; m_sc = 7; end
                7: case (m_op)
                    3'd0: begin m_ac = m_ac & m_dr; m_sc = 0; end
                    3'd1: begin {m_e, m_ac} = {1'b0, m_ac} + {1'b0, m_dr}; m_sc = 0; end
                    3'd2: begin m_ac = m_dr; m_sc = 0; end
                    default: begin m_dr = m_dr + 1; m_sc = 8; end
                endcase
                default: begin
                    ref_mem[m_ar] = m_dr;
                    if (m_dr == 0) m_pc = m_pc + 1;
                    m_sc = 0;
                end
            endcase
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            logic        gate, exp_we;
            logic [2:0]  op;
            logic [1:0]  exp_strobe;
            logic [15:0] exp_wd;
            gate = m_halted || halt;
            op   = m_ir[14:12];
            exp_we = !gate && ((m_sc == 5 && (op == 3'd3 || op == 3'd5)) || (m_sc == 8 && op == 3'd6));
            exp_strobe = (!gate && m_sc == 3 && op == 3'd7) ? (m_ir[15] ? 2'b10 : 2'b01) : 2'b00;
            exp_wd = (op == 3'd3) ? m_ac : (op == 3'd5) ? {4'h0, m_pc} : m_dr;
            check("R2", "pc", pc_o, m_pc);
            check("R2", "mem_addr", mem_addr, m_ar);
            check("R5", "acc", acc_o, m_ac);
            check("R5", "e", e_o, m_e);
            check("R3", "tstate", tstate_o, 32'(1) << m_sc);
            check("R6", "mem_we", mem_we, exp_we);
            if (exp_we) check("R6", "mem_wdata", mem_wdata, exp_wd);
            check("R10", "strobe", grp_strobe_o, exp_strobe);
            if (grp_strobe_o[0]) n_reg_strobe++;
            if (grp_strobe_o[1]) n_io_strobe++;
            if (tstate_o[1] && mem_addr == 12'h030) saw_030 = 1;
            if (tstate_o[1] && mem_addr == 12'h019) saw_019 = 1;
        end
    end

    task automatic put(input logic [11:0] a, input logic [15:0] w);
        mem[a] = w;
        ref_mem[a] = w;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [11:0] h_pc;
        logic [15:0] h_ac, h_t;
        for (int k = 0; k < 4096; k++) begin mem[k] = 0; ref_mem[k] = 0; end
        put(12'h010, 16'h2100); // LDA 100
        put(12'h011, 16'h1101); // ADD 101, carry out
        put(12'h012, 16'h8102); // AND indirect via 102
        put(12'h013, 16'h3104); // STA 104
        put(12'h014, 16'h1105); // ADD 105, no carry
        put(12'h015, 16'h7800); // code 7, register group
        put(12'h016, 16'hF400); // code 7, I/O group
        put(12'h017, 16'h6106); // ISZ 106, no skip
        put(12'h018, 16'h6106); // ISZ 106, wraps, skip
        put(12'h019, 16'h2100); // skipped
        put(12'h01A, 16'h5200); // BSA 200
        put(12'h201, 16'hA107); // LDA indirect via 107
        put(12'h202, 16'hB108); // STA indirect via 108
        put(12'h203, 16'hC200); // BUN indirect via 200 (return)
        put(12'h01B, 16'h4030); // BUN 030
        put(12'h030, 16'h110A); // ADD 10A, result zero with carry
        put(12'h031, 16'h4031); // loop
        put(12'h100, 16'h8001);
        put(12'h101, 16'h8002);
        put(12'h102, 16'h0103);
        put(12'h103, 16'h0001);
        put(12'h105, 16'h0004);
        put(12'h106, 16'hFFFE);
        put(12'h107, 16'h0104);
        put(12'h108, 16'h0109);
        put(12'h10A, 16'hFFFF);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset pc", pc_o, 12'h010);
        check("R1", "reset acc", acc_o, 0);
        check("R1", "reset e", e_o, 0);
        check("R1", "reset tstate", tstate_o, 16'h0001);
        check("R1", "reset we", mem_we, 0);
        #1 rst_n = 1'b1;
        chk_on = 1;

        repeat (400) @(posedge clk);
        @(negedge clk);
        check("R4", "indirect store target", mem[12'h109], 16'h0001);
        check("R4", "indirect AND result stored", mem[12'h104], 16'h0001);
        check("R5", "final acc", acc_o, 16'h0000);
        check("R5", "final e after carry", e_o, 1);
        check("R8", "return address saved", mem[12'h200], 16'h001B);
        check("R9", "ISZ writeback", mem[12'h106], 16'h0000);
        check("R9", "skipped word fetched", saw_019, 0);
        check("R7", "branch target fetched", saw_030, 1);
        check("R10", "register strobes", n_reg_strobe, 1);
        check("R10", "I/O strobes", n_io_strobe, 1);

        #1 halt = 1'b1;
        @(negedge clk);
        h_pc = pc_o; h_ac = acc_o; h_t = tstate_o;
        #1 halt = 1'b0;
        repeat (20) begin
            @(negedge clk);
            check("R11", "halted pc", pc_o, h_pc);
            check("R11", "halted acc", acc_o, h_ac);
            check("R11", "halted tstate", tstate_o, h_t);
            check("R11", "halted we", mem_we, 0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule